// File: doc/BRIEF.md
# Indirectly Addressed System Timer Controller

A global timer for a multi-core system. A 64-bit free-running count is shared by all cores. It advances on a prescaled version of a reference tick pulse, and the prescaler is chosen by a one-hot divide field. Each core has its own 64-bit compare value and its own interrupt line. That line is raised while the count has reached the compare value and the core's bit in the interrupt enable mask is set.

Software never addresses the internal registers directly. On a simple 32-bit bus the block exposes a two-word window. Software first writes an internal index into the index word, then reads or writes the data word, which acts on the register selected by that index. A read-modify-write through the window therefore takes an index write followed by a data read and a data write.

Top module: `systimer_ctl`

## Requirements
- R1: The bus window decodes byte offset 0x4 as the index word (all 32 bits stored and read back) and byte offset 0x0 as the data word, which reads or writes the internal register named by the last written index; any other offset reads zero and its writes are ignored.
- R2: After a synchronous active-high reset every register, the index and the count are zero, so the timer is disabled and every core interrupt is low.
- R3: Internal index 0x0 is the control word; all 32 bits read back exactly as written, bit 0 enables counting, and while bit 0 is clear the count holds.
- R4: Control bits 10:8 select the prescaler one-hot: 001 advances the count on every reference tick, 010 on every second tick, 100 on every fourth tick (a 26 MHz tick stream gives a 13 MHz count under 010). Prescaler phase advances only on enabled ticks.
- R5: A divide field of 000 or with more than one bit set behaves as divide-by-1.
- R6: The count reads at internal index 0x8 (bits 31:0) and 0xC (bits 63:32); writes to these indices are ignored.
- R7: Internal index 0x30 is the interrupt enable mask, bit c for core c; bits at and above the core count read zero. Clearing a core's bit drops its interrupt without affecting the count.
- R8: Core c's compare value sits at internal index 0x40+8c (bits 31:0) and 0x44+8c (bits 63:32); core c's interrupt is high while count >= compare and mask bit c is set.
- R9: A compare placed 3 counts ahead fires exactly on the third advance, and one placed 0xFFFFFFFF counts ahead carries into the upper word and does not fire early.
- R10: Unmapped internal indices read zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Reference tick pulse, one clock wide per tick |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and state |
| core_irq | output | NUM_CORES | Per-core interrupt level |

## Verification
The assertions take for granted that the reference tick arrives as single-clock pulses and that the divide field stays put between an advance and the cycle after it whenever the one-hot spacing is checked. The stimulus keeps to this. Ticks are driven only while the bus is idle, as isolated one-cycle pulses. The divide field is rewritten only between tick bursts. Compare values are loaded while the interrupt mask is still clear, so a half-written 64-bit compare never reaches an interrupt line.

// File: rtl/systimer_pkg.sv
package systimer_pkg;

    localparam int CNT_W = 64;

    // bus window byte offsets
    localparam logic [7:0] WIN_DATA  = 8'h0;
    localparam logic [7:0] WIN_INDEX = 8'h4;

    // internal indices
    localparam logic [31:0] IDX_CTRL     = 32'h0;
    localparam logic [31:0] IDX_CNT_LO   = 32'h8;
    localparam logic [31:0] IDX_CNT_HI   = 32'hC;
    localparam logic [31:0] IDX_IRQ_MASK = 32'h30;
    localparam logic [31:0] IDX_CMP_BASE = 32'h40;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DIV_LSB = 8;

    typedef enum logic [2:0] {
        DIV_BY1 = 3'b001,
        DIV_BY2 = 3'b010,
        DIV_BY4 = 3'b100
    } div_sel_e;

    // prescaler phase bits that must be all ones for an advance
    function automatic logic [1:0] div_phase_mask(input logic [2:0] sel);
        case (sel)
            DIV_BY2: return 2'b01;
            DIV_BY4: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/systimer_regs.sv
module systimer_regs
    import systimer_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [CNT_W-1:0]              count,
    output logic [31:0]                   ctrl_q,
    output logic [NUM_CORES-1:0]          mask_q,
    output logic [NUM_CORES-1:0][CNT_W-1:0] cmp_q
);

    logic [31:0]          index_q;
    logic                 at_data, at_index, data_wr, index_wr;
    logic [NUM_CORES-1:0] hit_lo, hit_hi;
    logic                 idx_mapped;
    logic [31:0]          reg_rd;

    assign at_data  = (8'(bus_addr) == WIN_DATA);
    assign at_index = (8'(bus_addr) == WIN_INDEX);
    assign data_wr  = bus_sel && bus_wr && at_data;
    assign index_wr = bus_sel && bus_wr && at_index;

    assign idx_mapped = (index_q == IDX_CTRL) || (index_q == IDX_IRQ_MASK) ||
                        (index_q == IDX_CNT_LO) || (index_q == IDX_CNT_HI) ||
                        (|hit_lo) || (|hit_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            ctrl_q  <= '0;
            mask_q  <= '0;
        end else begin
            if (index_wr) index_q <= bus_wdata;
            if (data_wr && index_q == IDX_CTRL) ctrl_q <= bus_wdata;
            if (data_wr && index_q == IDX_IRQ_MASK) mask_q <= bus_wdata[NUM_CORES-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
        assign hit_lo[c] = (index_q == IDX_CMP_BASE + 32'(8 * c));
        assign hit_hi[c] = (index_q == IDX_CMP_BASE + 32'(8 * c + 4));
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[c] <= '0;
            end else if (data_wr) begin
                if (hit_lo[c]) cmp_q[c][31:0]  <= bus_wdata;
                if (hit_hi[c]) cmp_q[c][63:32] <= bus_wdata;
            end
        end
    end

    always_comb begin
        reg_rd = '0;
        if (index_q == IDX_CTRL)     reg_rd = ctrl_q;
        if (index_q == IDX_IRQ_MASK) reg_rd = 32'(mask_q);
        if (index_q == IDX_CNT_LO)   reg_rd = count[31:0];
        if (index_q == IDX_CNT_HI)   reg_rd = count[63:32];
        for (int c = 0; c < NUM_CORES; c++) begin
            if (hit_lo[c]) reg_rd = cmp_q[c][31:0];
            if (hit_hi[c]) reg_rd = cmp_q[c][63:32];
        end
    end

    assign bus_rdata = at_index ? index_q : (at_data ? reg_rd : 32'h0);

    // R10: a data write to an unmapped index leaves all registers unchanged
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !idx_mapped) |=> ($stable(ctrl_q) && $stable(mask_q) && $stable(cmp_q)));

endmodule

// File: rtl/systimer_tickgen.sv
module systimer_tickgen
    import systimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic             enable,
    input  logic [2:0]       div_sel,
    output logic [CNT_W-1:0] count,
    output logic             advance
);

    logic [1:0] pre_q;
    logic [1:0] phase_mask;

    assign phase_mask = div_phase_mask(div_sel);
    assign advance    = enable && tick_in && ((pre_q & phase_mask) == phase_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            count <= '0;
        end else if (enable && tick_in) begin
            pre_q <= pre_q + 2'd1;
            if (advance) count <= count + 1'b1;
        end
    end

    // R3: count holds while counting is disabled
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(count));

    // R4: without a tick the count never moves
    p_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_in |=> $stable(count));

    // R4: with a tick the count steps by at most one
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        tick_in |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R4: divide-by-4 never advances on two successive ticks
    p_div4_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && div_sel == DIV_BY4) |=> (div_sel != DIV_BY4 || !advance));

endmodule

// File: rtl/systimer_match.sv
module systimer_match
    import systimer_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [CNT_W-1:0]                count,
    input  logic [NUM_CORES-1:0]            mask_q,
    input  logic [NUM_CORES-1:0][CNT_W-1:0] cmp_q,
    output logic [NUM_CORES-1:0]            core_irq
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign core_irq[c] = mask_q[c] && (count >= cmp_q[c]);
    end

endmodule

// File: rtl/systimer_ctl.sv
module systimer_ctl
    import systimer_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] core_irq
);

    logic [CNT_W-1:0]                count;
    logic                            advance;
    logic [31:0]                     ctrl_q;
    logic [NUM_CORES-1:0]            mask_q;
    logic [NUM_CORES-1:0][CNT_W-1:0] cmp_q;

    systimer_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .ctrl_q(ctrl_q), .mask_q(mask_q), .cmp_q(cmp_q)
    );

    systimer_tickgen u_tick (
        .clk(clk), .rst(rst), .tick_in(tick_in),
        .enable(ctrl_q[CTRL_EN_BIT]),
        .div_sel(ctrl_q[CTRL_DIV_LSB +: 3]),
        .count(count), .advance(advance)
    );

    systimer_match #(.NUM_CORES(NUM_CORES)) u_match (
        .count(count), .mask_q(mask_q), .cmp_q(cmp_q), .core_irq(core_irq)
    );

    // R2: right after reset every interrupt is low
    p_reset_quiet_r2: assert property (@(posedge clk)
        rst |=> (core_irq == '0));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R8: an interrupt rises only when the count moved, the mask bit rose or the compare changed
        p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(core_irq[c]) |-> (count != $past(count) || $rose(mask_q[c]) ||
                                    cmp_q[c] != $past(cmp_q[c])));
        // R7: clearing the mask bit drops the interrupt on the next cycle
        p_mask_drop_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(mask_q[c]) |-> !core_irq[c]);
    end

endmodule

// File: tb/systimer_ctl_bench.sv
module systimer_ctl_bench;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] core_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    systimer_ctl #(.NUM_CORES(NC), .ADDR_W(4)) u_systimer_ctl (
        .clk(clk), .rst(rst), .tick_in(tick_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq(core_irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0]    m_index, m_ctrl, m_mask;
    longint unsigned m_cnt;
    longint unsigned m_cmp [NC];
    int             m_phase;

    function automatic int div_of(input logic [2:0] f);
        if (f == 3'b010) return 2;
        if (f == 3'b100) return 4;
        return 1;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] idx);
        if (idx == 32'h0)  return m_ctrl;
        if (idx == 32'h30) return m_mask;
        if (idx == 32'h8)  return m_cnt[31:0];
        if (idx == 32'hC)  return m_cnt[63:32];
        for (int c = 0; c < NC; c++) begin
            if (idx == 32'h40 + 32'(8 * c)) return m_cmp[c][31:0];
            if (idx == 32'h44 + 32'(8 * c)) return m_cmp[c][63:32];
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_index = 0; m_ctrl = 0; m_mask = 0; m_cnt = 0; m_phase = 0;
            for (int c = 0; c < NC; c++) m_cmp[c] = 0;
            model_on = 1'b1;
        end else begin
            if (m_ctrl[0] && tick_in) begin
                int d;
                d = div_of(m_ctrl[10:8]);
                if ((m_phase % d) == d - 1) m_cnt++;
                m_phase++;
            end
            if (bus_sel && bus_wr) begin
                if (bus_addr == 4'h4) m_index = bus_wdata;
                else if (bus_addr == 4'h0) begin
                    if (m_index == 32'h0)  m_ctrl = bus_wdata;
                    if (m_index == 32'h30) m_mask = bus_wdata & ((32'h1 << NC) - 1);
                    for (int c = 0; c < NC; c++) begin
                        if (m_index == 32'h40 + 32'(8 * c)) m_cmp[c][31:0]  = bus_wdata;
                        if (m_index == 32'h44 + 32'(8 * c)) m_cmp[c][63:32] = bus_wdata;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (model_on && !rst && !finished) begin
            logic [NC-1:0] e_irq;
            logic [31:0]   e_rd;
            for (int c = 0; c < NC; c++) e_irq[c] = m_mask[c] && (m_cnt >= m_cmp[c]);
            if (bus_addr == 4'h4) e_rd = m_index;
            else if (bus_addr == 4'h0) e_rd = m_read(m_index);
            else e_rd = 32'h0;
            chk(core_irq == e_irq, "R8 model irq", 64'(core_irq), 64'(e_irq));
            chk(bus_rdata == e_rd, "R1 model rdata", 64'(bus_rdata), 64'(e_rd));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_write(input logic [3:0] ofs, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ofs; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [31:0] idx, input logic [31:0] d);
        bus_write(4'h4, idx);
        bus_write(4'h0, d);
    endtask

    task automatic rd_reg(input logic [31:0] idx, output logic [31:0] d);
        bus_write(4'h4, idx);
        bus_addr = 4'h0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick_in = 1'b1;
            @(posedge clk); #1 tick_in = 1'b0;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 50000 && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        rd_reg(32'h0, v);  chk(v == 0, "R2 ctrl after reset", 64'(v), 0);
        rd_reg(32'h30, v); chk(v == 0, "R2 mask after reset", 64'(v), 0);
        rd_reg(32'h8, v);  chk(v == 0, "R2 count after reset", 64'(v), 0);
        chk(core_irq == 0, "R2 irq after reset", 64'(core_irq), 0);

        // R1 window decode
        bus_write(4'h4, 32'hDEADBEEF);
        bus_addr = 4'h4; @(negedge clk);
        chk(bus_rdata == 32'hDEADBEEF, "R1 index readback", 64'(bus_rdata), 64'hDEADBEEF);
        bus_write(4'h8, 32'h12345678);
        bus_addr = 4'h8; @(negedge clk);
        chk(bus_rdata == 0, "R1 other offset reads zero", 64'(bus_rdata), 0);
        bus_addr = 4'h4; @(negedge clk);
        chk(bus_rdata == 32'hDEADBEEF, "R1 other offset write ignored", 64'(bus_rdata), 64'hDEADBEEF);

        // R3 control readback and hold while disabled
        wr_reg(32'h0, 32'hA5A5_F2F0);
        rd_reg(32'h0, v); chk(v == 32'hA5A5_F2F0, "R3 ctrl readback", 64'(v), 64'hA5A5F2F0);
        wr_reg(32'h0, 32'h0000_0200);
        run_ticks(6);
        rd_reg(32'h8, v); chk(v == 0, "R3 count holds when disabled", 64'(v), 0);

        // R4 divider: /2 then /4 then /1
        wr_reg(32'h0, 32'h0000_0201);
        run_ticks(8);
        rd_reg(32'h8, v); chk(v == 4, "R4 div2 8 ticks", 64'(v), 4);
        wr_reg(32'h0, 32'h0000_0401);
        run_ticks(8);
        rd_reg(32'h8, v); chk(v == 6, "R4 div4 8 ticks", 64'(v), 6);
        wr_reg(32'h0, 32'h0000_0101);
        run_ticks(5);
        rd_reg(32'h8, v); chk(v == 11, "R4 div1 5 ticks", 64'(v), 11);

        // R5 invalid divide fields
        wr_reg(32'h0, 32'h0000_0301);
        run_ticks(3);
        rd_reg(32'h8, v); chk(v == 14, "R5 two bits set acts as div1", 64'(v), 14);
        wr_reg(32'h0, 32'h0000_0001);
        run_ticks(2);
        rd_reg(32'h8, v); chk(v == 16, "R5 zero field acts as div1", 64'(v), 16);

        // R6 count is read-only, upper word zero
        wr_reg(32'h8, 32'h55);
        wr_reg(32'hC, 32'h77);
        rd_reg(32'h8, v); chk(v == 16, "R6 count low write ignored", 64'(v), 16);
        rd_reg(32'hC, v); chk(v == 0, "R6 count high write ignored", 64'(v), 0);

        // R10 unmapped index
        wr_reg(32'h20, 32'hFFFF_FFFF);
        rd_reg(32'h20, v); chk(v == 0, "R10 unmapped reads zero", 64'(v), 0);
        rd_reg(32'h0, v);  chk(v == 32'h1, "R10 ctrl untouched", 64'(v), 1);
        rd_reg(32'h30, v); chk(v == 0, "R10 mask untouched", 64'(v), 0);

        // R8/R9 compares loaded while masked
        wr_reg(32'h40, 32'd19);        wr_reg(32'h44, 32'h0);
        wr_reg(32'h48, 32'h0000_000F); wr_reg(32'h4C, 32'h1);
        wr_reg(32'h50, 32'hFFFF_FFFF); wr_reg(32'h54, 32'hFFFF_FFFF);
        rd_reg(32'h4C, v); chk(v == 1, "R8 compare high readback", 64'(v), 1);
        chk(core_irq == 0, "R7 all masked", 64'(core_irq), 0);

        // R7 mask upper bits read zero
        wr_reg(32'h30, 32'hFFFF_FFFF);
        rd_reg(32'h30, v); chk(v == 32'hF, "R7 mask width", 64'(v), 64'hF);
        chk(core_irq == 4'b1000, "R8 zero compare fires", 64'(core_irq), 64'b1000);

        run_ticks(2);
        @(negedge clk);
        chk(core_irq == 4'b1000, "R9 delta 3 not yet", 64'(core_irq), 64'b1000);
        run_ticks(1);
        @(negedge clk);
        chk(core_irq == 4'b1001, "R9 delta 3 fires on third", 64'(core_irq), 64'b1001);
        chk(core_irq[1] == 1'b0, "R9 large delta no early fire", 64'(core_irq[1]), 0);

        // R7 masking suppresses irq, count continues
        wr_reg(32'h30, 32'hE);
        @(negedge clk);
        chk(core_irq == 4'b1000, "R7 masked core drops", 64'(core_irq), 64'b1000);
        run_ticks(2);
        rd_reg(32'h8, v); chk(v == 21, "R7 count continues while masked", 64'(v), 21);

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule